// File: doc/BRIEF.md
# Masked Vector Compress/Expand Unit

This block rearranges the elements of a fixed-length vector under a per-element mask. In compress mode it gathers the elements whose mask bit is set and packs them, in their original order, into the lowest output positions; the output mask then marks how many leading positions carry valid data. In expand mode it does the reverse. Consecutive input elements, taken from element 0 upward, are placed into the positions whose mask bit is set. Unselected positions are cleared to zero, and the mask passes through unchanged.

An operation starts with a one-cycle `start` while the unit is idle. At that edge the unit captures the data, the mask and the mode. It then walks one position per clock, for `NUM_EL` clocks, and raises `done` for one cycle with the result on `out_data` and `out_mask`. The result stays on the outputs until the next operation is accepted. A new `start` is accepted in the same cycle that `done` is high, so operations can run back to back.

Element `i` occupies bits `[i*ELEM_W +: ELEM_W]` of a data bus. Mask bit `i` belongs to element `i`.

Top module: `vec_pack_unit`

## Requirements
- R1: With `mode`=0 (compress), the elements whose mask bit is 1 appear at output positions 0, 1, 2, ... in rising order of their input index. For the mask 8'b1001_1101 the first five outputs are elements 0, 2, 3, 4 and 7.
- R2: After a compress, `out_mask` has ones in its lowest k bits and zeros above them, where k is the number of ones in the captured mask. Positions at or above k carry no defined data.
- R3: With `mode`=1 (expand), output position p with mask bit 1 receives input element j, where j is the number of set mask bits below p.
- R4: After an expand, every output position whose mask bit is 0 reads zero, and `out_mask` equals the captured mask.
- R5: The mode is captured on the edge that accepts `start`. Changing `mode` later has no effect on the running operation.
- R6: `done` rises exactly `NUM_EL`+1 clock edges after the edge that accepted `start` (counting that edge as the first). It stays high for exactly one cycle, and `busy` is low while `done` is high.
- R7: While `busy` is high, `start`, `in_data`, `in_mask` and `mode` are ignored. No extra operation is started and the result is unaffected.
- R8: An all-zero mask gives an all-zero `out_mask` in both modes. In expand mode the data also reads all zero.
- R9: An all-ones mask returns the input data unchanged and an all-ones `out_mask` in both modes.
- R10: After reset `busy`, `done`, `out_mask` and `out_data` are all zero.
- R11: A `start` presented in the cycle where `done` is high is accepted as a new operation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin an operation; honoured only while idle |
| mode | input | 1 | 0 = compress, 1 = expand; captured with start |
| in_data | input | NUM_EL*ELEM_W | Source vector, element i at bits [i*ELEM_W +: ELEM_W] |
| in_mask | input | NUM_EL | Selection mask, bit i for element i |
| busy | output | 1 | An operation is in progress |
| done | output | 1 | One-cycle pulse: result valid |
| out_data | output | NUM_EL*ELEM_W | Rearranged vector |
| out_mask | output | NUM_EL | Validity mask of the result |

## Verification
Two events can fall on the same clock: the completion of one operation, with its `done` pulse, and the acceptance of the next `start`. The bench provokes this by waiting for `done` and presenting a new request, with a different mode, in that same cycle. It then judges both results against its own model. It also checks the second result's latency from that cycle, and that exactly one `done` pulse appears per request. A separate run drives start pulses, a flipped mode and garbage data while the unit is busy. The scoreboard then shows that only the captured request produced a result.

// File: rtl/vpu_pkg.sv
package vpu_pkg;
  typedef enum logic {
    VPU_PACK    = 1'b0,
    VPU_SCATTER = 1'b1
  } vpu_mode_e;
endpackage

// File: rtl/vpu_ctrl.sv
module vpu_ctrl #(
  parameter int NUM_EL = 8
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      start,
  output logic                      load,
  output logic                      busy,
  output logic                      last,
  output logic [$clog2(NUM_EL)-1:0] idx,
  output logic                      done
);
  localparam int IDX_W = $clog2(NUM_EL);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_EL - 1);

  logic             busy_q;
  logic             done_q;
  logic [IDX_W-1:0] idx_q;

  assign load = start && !busy_q;
  assign last = busy_q && (idx_q == LAST_IDX);

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q <= 1'b0;
      done_q <= 1'b0;
      idx_q  <= '0;
    end else begin
      done_q <= 1'b0;
      if (load) begin
        busy_q <= 1'b1;
        idx_q  <= '0;
      end else if (busy_q) begin
        if (last) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
        end else begin
          idx_q <= idx_q + 1'b1;
        end
      end
    end
  end

  assign busy = busy_q;
  assign idx  = idx_q;
  assign done = done_q;

  assert_done_pulse_R6: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  assert_done_idle_R6: assert property (@(posedge clk) disable iff (rst)
    done |-> (!busy && $past(busy)));
  assert_load_busy_R7: assert property (@(posedge clk) disable iff (rst)
    load |=> (busy && idx == '0));
  assert_walk_R6: assert property (@(posedge clk) disable iff (rst)
    (busy && !last) |=> (busy && idx == $past(idx) + 1'b1));
endmodule

// File: rtl/vpu_route.sv
module vpu_route
  import vpu_pkg::*;
#(
  parameter int ELEM_W = 16,
  parameter int NUM_EL = 8
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       load,
  input  logic                       step,
  input  logic [$clog2(NUM_EL)-1:0]  idx,
  input  logic [NUM_EL*ELEM_W-1:0]   in_data,
  input  logic [NUM_EL-1:0]          in_mask,
  input  logic                       in_mode,
  output vpu_mode_e                  mode_q,
  output logic [NUM_EL-1:0]          mask_q,
  output logic [NUM_EL-1:0]          wr_en,
  output logic [ELEM_W-1:0]          wr_val,
  output logic [$clog2(NUM_EL+1)-1:0] cnt_fin
);
  localparam int IDX_W = $clog2(NUM_EL);
  localparam int CNT_W = $clog2(NUM_EL + 1);

  logic [NUM_EL*ELEM_W-1:0] data_q;
  logic [CNT_W-1:0]         ptr_q;
  logic                     cur_bit;
  logic [IDX_W-1:0]         src_idx;
  logic [ELEM_W-1:0]        src_elem;

  always_ff @(posedge clk) begin
    if (rst) begin
      data_q <= '0;
      mask_q <= '0;
      mode_q <= VPU_PACK;
      ptr_q  <= '0;
    end else if (load) begin
      data_q <= in_data;
      mask_q <= in_mask;
      mode_q <= vpu_mode_e'(in_mode);
      ptr_q  <= '0;
    end else if (step) begin
      ptr_q <= cnt_fin;
    end
  end

  assign cur_bit  = mask_q[idx];
  assign cnt_fin  = ptr_q + CNT_W'(cur_bit);
  assign src_idx  = (mode_q == VPU_PACK) ? idx : ptr_q[IDX_W-1:0];
  assign src_elem = data_q[src_idx*ELEM_W +: ELEM_W];

  always_comb begin
    wr_val = src_elem;
    if (mode_q == VPU_SCATTER && !cur_bit) wr_val = '0;
  end

  for (genvar k = 0; k < NUM_EL; k++) begin : g_sel
    always_comb begin
      if (!step)                  wr_en[k] = 1'b0;
      else if (mode_q == VPU_PACK) wr_en[k] = cur_bit && (ptr_q == CNT_W'(k));
      else                         wr_en[k] = (idx == IDX_W'(k));
    end
  end

  assert_ptr_bound_R1: assert property (@(posedge clk) disable iff (rst)
    step |-> (ptr_q <= CNT_W'(idx)));
  assert_hold_mode_R5: assert property (@(posedge clk) disable iff (rst)
    step |=> $stable(mode_q));
  assert_hold_src_R7: assert property (@(posedge clk) disable iff (rst)
    step |=> ($stable(data_q) && $stable(mask_q)));
endmodule

// File: rtl/vpu_lane_bank.sv
module vpu_lane_bank #(
  parameter int ELEM_W = 16,
  parameter int NUM_EL = 8
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     load,
  input  logic [NUM_EL-1:0]        wr_en,
  input  logic [ELEM_W-1:0]        wr_val,
  output logic [NUM_EL*ELEM_W-1:0] lanes
);
  for (genvar k = 0; k < NUM_EL; k++) begin : g_lane
    logic [ELEM_W-1:0] slot_q;
    always_ff @(posedge clk) begin
      if (rst || load)   slot_q <= '0;
      else if (wr_en[k]) slot_q <= wr_val;
    end
    assign lanes[k*ELEM_W +: ELEM_W] = slot_q;
  end

  assert_one_write_R1: assert property (@(posedge clk) disable iff (rst)
    $onehot0(wr_en));
  assert_no_write_on_load_R7: assert property (@(posedge clk) disable iff (rst)
    load |-> (wr_en == '0));
endmodule

// File: rtl/vpu_mask_gen.sv
module vpu_mask_gen
  import vpu_pkg::*;
#(
  parameter int NUM_EL = 8
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        load,
  input  logic                        finish,
  input  vpu_mode_e                   mode_q,
  input  logic [NUM_EL-1:0]           mask_q,
  input  logic [$clog2(NUM_EL+1)-1:0] cnt_fin,
  output logic [NUM_EL-1:0]           out_mask
);
  localparam int CNT_W = $clog2(NUM_EL + 1);

  logic [NUM_EL-1:0] prefix;

  for (genvar k = 0; k < NUM_EL; k++) begin : g_pre
    assign prefix[k] = (CNT_W'(k) < cnt_fin);
  end

  always_ff @(posedge clk) begin
    if (rst || load)  out_mask <= '0;
    else if (finish)  out_mask <= (mode_q == VPU_PACK) ? prefix : mask_q;
  end

  assert_cnt_range_R2: assert property (@(posedge clk) disable iff (rst)
    finish |-> (cnt_fin <= CNT_W'(NUM_EL)));
endmodule

// File: rtl/vec_pack_unit.sv
module vec_pack_unit
  import vpu_pkg::*;
#(
  parameter int ELEM_W = 16,
  parameter int NUM_EL = 8
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     start,
  input  logic                     mode,
  input  logic [NUM_EL*ELEM_W-1:0] in_data,
  input  logic [NUM_EL-1:0]        in_mask,
  output logic                     busy,
  output logic                     done,
  output logic [NUM_EL*ELEM_W-1:0] out_data,
  output logic [NUM_EL-1:0]        out_mask
);
  localparam int IDX_W = $clog2(NUM_EL);
  localparam int CNT_W = $clog2(NUM_EL + 1);

  logic              load;
  logic              last;
  logic [IDX_W-1:0]  idx;
  vpu_mode_e         mode_q;
  logic [NUM_EL-1:0] mask_q;
  logic [NUM_EL-1:0] wr_en;
  logic [ELEM_W-1:0] wr_val;
  logic [CNT_W-1:0]  cnt_fin;

  vpu_ctrl #(.NUM_EL(NUM_EL)) u_ctrl (
    .clk(clk), .rst(rst), .start(start), .load(load), .busy(busy),
    .last(last), .idx(idx), .done(done)
  );

  vpu_route #(.ELEM_W(ELEM_W), .NUM_EL(NUM_EL)) u_route (
    .clk(clk), .rst(rst), .load(load), .step(busy), .idx(idx),
    .in_data(in_data), .in_mask(in_mask), .in_mode(mode),
    .mode_q(mode_q), .mask_q(mask_q), .wr_en(wr_en), .wr_val(wr_val),
    .cnt_fin(cnt_fin)
  );

  vpu_lane_bank #(.ELEM_W(ELEM_W), .NUM_EL(NUM_EL)) u_bank (
    .clk(clk), .rst(rst), .load(load), .wr_en(wr_en), .wr_val(wr_val),
    .lanes(out_data)
  );

  vpu_mask_gen #(.NUM_EL(NUM_EL)) u_mask (
    .clk(clk), .rst(rst), .load(load), .finish(last), .mode_q(mode_q),
    .mask_q(mask_q), .cnt_fin(cnt_fin), .out_mask(out_mask)
  );

  assert_pack_prefix_R2: assert property (@(posedge clk) disable iff (rst)
    (done && mode_q == VPU_PACK) |-> ((NUM_EL'(out_mask + 1'b1) & out_mask) == '0));
  assert_pack_count_R2: assert property (@(posedge clk) disable iff (rst)
    (done && mode_q == VPU_PACK) |-> ($countones(out_mask) == $countones(mask_q)));
  assert_scatter_mask_R4: assert property (@(posedge clk) disable iff (rst)
    (done && mode_q == VPU_SCATTER) |-> (out_mask == mask_q));

  for (genvar k = 0; k < NUM_EL; k++) begin : g_chk
    assert_scatter_zero_R4: assert property (@(posedge clk) disable iff (rst)
      (done && mode_q == VPU_SCATTER && !out_mask[k]) |->
        (out_data[k*ELEM_W +: ELEM_W] == '0));
  end
endmodule

// File: tb/sim_vec_pack_unit.sv
module sim_vec_pack_unit;
  localparam int W  = 16;
  localparam int N  = 8;
  localparam int DW = N * W;

  typedef struct {
    logic [DW-1:0] d;
    logic [N-1:0]  m;
    logic [N-1:0]  care;
    int            issue;
    logic [63:0]   tag;
  } exp_t;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          start = 1'b0;
  logic          mode = 1'b0;
  logic [DW-1:0] in_data = '0;
  logic [N-1:0]  in_mask = '0;
  logic          busy, done;
  logic [DW-1:0] out_data;
  logic [N-1:0]  out_mask;

  int   checks = 0;
  int   errors = 0;
  int   cyc = 0;
  bit   finished = 1'b0;
  bit   prev_done = 1'b0;
  exp_t sb[$];

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  vec_pack_unit #(.ELEM_W(W), .NUM_EL(N)) u0 (
    .clk(clk), .rst(rst), .start(start), .mode(mode), .in_data(in_data),
    .in_mask(in_mask), .busy(busy), .done(done), .out_data(out_data),
    .out_mask(out_mask)
  );

  function automatic exp_t model(bit md, logic [DW-1:0] d, logic [N-1:0] m);
    exp_t e;
    int   k = 0;
    e.d = '0; e.m = '0; e.care = '0; e.issue = 0; e.tag = '0;
    if (!md) begin
      for (int i = 0; i < N; i++) begin
        if (m[i]) begin
          e.d[k*W +: W] = d[i*W +: W];
          e.m[k] = 1'b1;
          k++;
        end
      end
      e.care = e.m;
    end else begin
      for (int p = 0; p < N; p++) begin
        if (m[p]) begin
          e.d[p*W +: W] = d[k*W +: W];
          k++;
        end
      end
      e.m = m;
      e.care = '1;
    end
    return e;
  endfunction

  function automatic logic [DW-1:0] pattern(int seed);
    logic [DW-1:0] v;
    for (int i = 0; i < N; i++) v[i*W +: W] = W'(16'hA000 + seed * 16 + i);
    return v;
  endfunction

  task automatic present(bit md, logic [DW-1:0] d, logic [N-1:0] m, logic [63:0] tag);
    exp_t e;
    e = model(md, d, m);
    e.issue = cyc;
    e.tag = tag;
    start = 1'b1; mode = md; in_data = d; in_mask = m;
    sb.push_back(e);
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic issue(bit md, logic [DW-1:0] d, logic [N-1:0] m,
                       logic [63:0] tag, bit disturb);
    @(negedge clk);
    while (busy) @(negedge clk);
    present(md, d, m, tag);
    if (disturb) begin
      for (int t = 0; t < N - 2; t++) begin
        start = 1'b1; mode = ~md; in_data = ~d; in_mask = ~m;
        @(negedge clk);
      end
      start = 1'b0;
    end
  endtask

  // Monitor: pops expected items and compares when done is seen.
  always @(negedge clk) begin
    if (!rst && !finished) begin
      if (done) begin
        checks++;
        if (prev_done) begin
          errors++;
          $display("FAIL R6 done high two cycles: actual 2 expected 1");
        end
        if (sb.size() == 0) begin
          errors++;
          $display("FAIL R7 unexpected done: actual 1 expected 0");
        end else begin
          exp_t e;
          bit   ok;
          e = sb.pop_front();
          checks++;
          if (busy || (cyc - e.issue) != N + 1) begin
            errors++;
            $display("FAIL R6 (%0s) latency/busy: actual %0d/%0b expected %0d/0",
                     e.tag, cyc - e.issue, busy, N + 1);
          end
          checks++;
          if (out_mask !== e.m) begin
            errors++;
            $display("FAIL %0s mask: actual %b expected %b", e.tag, out_mask, e.m);
          end
          ok = 1'b1;
          for (int i = 0; i < N; i++)
            if (e.care[i] && out_data[i*W +: W] !== e.d[i*W +: W]) ok = 1'b0;
          checks++;
          if (!ok) begin
            errors++;
            $display("FAIL %0s data: actual %h expected %h care %b",
                     e.tag, out_data, e.d, e.care);
          end
        end
      end
      prev_done = done;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      errors++;
      $display("FAIL R6 watchdog: actual timeout expected completion");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R10: reset state
    checks++;
    if (busy !== 1'b0 || done !== 1'b0 || out_mask !== '0 || out_data !== '0) begin
      errors++;
      $display("FAIL R10 reset: actual %b%b %b %h expected 00 0 0",
               busy, done, out_mask, out_data);
    end
    // R1 R2: example mask, elements 0,2,3,4,7 packed low
    issue(1'b0, pattern(1), 8'b1001_1101, "R1 R2", 1'b0);
    issue(1'b1, pattern(2), 8'b1001_1101, "R3 R4", 1'b0);
    issue(1'b0, pattern(3), 8'b1000_0000, "R1 R2", 1'b0);
    issue(1'b0, pattern(4), 8'b0000_0001, "R1 R2", 1'b0);
    issue(1'b1, pattern(5), 8'b0110_0000, "R3 R4", 1'b0);
    issue(1'b1, pattern(6), 8'b0000_0001, "R3 R4", 1'b0);
    // R8: all-zero mask
    issue(1'b0, pattern(7), 8'b0000_0000, "R8", 1'b0);
    issue(1'b1, pattern(8), 8'b0000_0000, "R8", 1'b0);
    // R9: all-ones mask
    issue(1'b0, pattern(9), 8'b1111_1111, "R9", 1'b0);
    issue(1'b1, pattern(10), 8'b1111_1111, "R9", 1'b0);
    // R5 R7: mode, data, mask and start disturbed while busy
    issue(1'b0, pattern(11), 8'b0101_0110, "R5 R7", 1'b1);
    issue(1'b1, pattern(12), 8'b1010_0011, "R5 R7", 1'b1);
    // R11: new start presented in the done cycle
    issue(1'b1, pattern(13), 8'b1100_1010, "R3 R11", 1'b0);
    while (!done) @(negedge clk);
    present(1'b0, pattern(14), 8'b0011_0101, "R1 R11");
    while (!done) @(negedge clk);
    present(1'b1, pattern(15), 8'b0111_1110, "R4 R11");
    repeat (3 * N) @(negedge clk);
    checks++;
    if (sb.size() != 0) begin
      errors++;
      $display("FAIL R11 pending results: actual %0d expected 0", sb.size());
    end
    finished = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule